// File: doc/BRIEF.md
# LED Screen Bus Write Interface

This block sits between a 16-bit memory-mapped processor bus and a wall of chained LED tiles. The screen is seen by the processor as a linear memory region. When the bus starts a write to that region, the block captures the address, the data and the current vertical tier setting at the moment the chip select goes low. When the write enable follows, the block raises the first-level column write strobe, after the captured data is already stable at the tile inputs.

The captured address is split into two fields. Address bits [4:1] give the first-level latch index inside a tile. Address bits [8:5] are decoded into a one-hot horizontal tile select. The vertical position does not come from the address. A 3-bit side setting picks one of eight tier pairs, and only that pair receives the strobe. Each halfword carries two bytes: the low byte goes to one tier and the high byte to the vertically adjacent tier, at the same row, column and latch.

The row index and the second-level transfer strobe are set by software. The block registers them and passes them to the screen.

Top module: `ledbus_wr_if`

## Requirements
- R1: While reset is held, all of these are zero: latch index, both data bytes, tier-pair enables, column write strobe, row index and transfer strobe. The tile select is 16'h0001 (tile 0).
- R2: A write is captured at the first clock edge where chip select is sampled low after being high, the access is a write, and the address lies in 0x2000000..0x3FFFFFF. From the next cycle, `latchIdx` equals address bits [4:1], `loByte` equals data bits [7:0] and `hiByte` equals data bits [15:8].
- R3: `tileSel` is always one-hot. Bit n is set when the captured address bits [8:5] equal n.
- R4: While the column write strobe is high, exactly one bit of `tierWrEn` is set: the bit indexed by the tier setting captured with the address. While the strobe is low, `tierWrEn` is zero.
- R5: `colWrStb` is high in the cycle after write enable is sampled low during a captured access. It is low in the cycle after write enable or chip select is sampled high.
- R6: A write to an address outside the screen region leaves latch index, tile select and bytes unchanged, and raises no strobe.
- R7: A read, even to the screen region, leaves latch index, tile select and bytes unchanged, and raises no strobe.
- R8: While chip select stays low, changes on the address, data and tier inputs do not alter the captured values.
- R9: `rowIdx` and `xferStb` follow the row and transfer control inputs with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 26 | Byte address from the processor bus |
| busData | input | 16 | Write data from the processor bus |
| busWr | input | 1 | 1 for a write access, 0 for a read |
| csN | input | 1 | Active-low chip select for the screen bank |
| weN | input | 1 | Active-low write enable |
| tierCfg | input | 3 | Vertical tier-pair setting from a side register |
| rowCfg | input | 4 | Scan row index from software |
| xferCfg | input | 1 | Second-level transfer control bit from software |
| latchIdx | output | 4 | First-level latch index inside the tile |
| tileSel | output | 16 | One-hot horizontal tile select |
| tierWrEn | output | 8 | Strobe routed to the selected tier pair |
| loByte | output | 8 | Byte for the first tier of the pair |
| hiByte | output | 8 | Byte for the adjacent tier of the pair |
| colWrStb | output | 1 | First-level column write strobe |
| rowIdx | output | 4 | Registered scan row index |
| xferStb | output | 1 | Registered second-level transfer strobe |

## Verification
The captured latch index, tile select and bytes appear one cycle after the edge that samples the falling chip select. The column strobe and the tier enables appear one edge after write enable is sampled low, and clear one edge after write enable or chip select returns high. The row index and transfer strobe lag their inputs by one edge. The bench drives inputs on the falling clock edge and samples on the next falling edge, so every check lands exactly one register stage after its cause. Accesses that must have no effect are checked at that same point against the values held from the previous capture.

// File: rtl/ledbus_pkg.sv
package ledbus_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic capture;  // load the holding registers this cycle
    logic wrStb;    // registered first-level write strobe
  } busStb_t;
endpackage

// File: rtl/ledbus_ctrl.sv
module ledbus_ctrl
  import ledbus_pkg::*;
#(
  parameter int          ADDR_W      = 26,
  parameter logic [25:0] BASE_ADDR   = 26'h2000000,
  parameter int          REGION_LOG2 = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              csN,
  input  logic              weN,
  output busStb_t           stb
);
  localparam int TAG_W = ADDR_W - REGION_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:REGION_LOG2];

  logic csPrev;
  logic armed;
  logic wrStbQ;
  logic regionHit;
  logic csFall;

  assign regionHit = (busAddr[ADDR_W-1:REGION_LOG2] == BASE_TAG);
  assign csFall    = !csN && csPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev <= 1'b1;
      armed  <= 1'b0;
      wrStbQ <= 1'b0;
    end else begin
      csPrev <= csN;
      if (csN) begin
        armed <= 1'b0;
      end else if (csFall && regionHit && busWr) begin
        armed <= 1'b1;
      end
      wrStbQ <= !csN && armed && !weN;
    end
  end

  assign stb.capture = csFall && regionHit && busWr;
  assign stb.wrStb   = wrStbQ;
endmodule

// File: rtl/ledbus_dp.sv
module ledbus_dp
  import ledbus_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 16,
  parameter int LATCH_LSB = 1,
  parameter int LATCH_W   = 4,
  parameter int TILE_W    = 4,
  parameter int TIER_W    = 3,
  parameter int ROW_W     = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busStb_t                   stb,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busData,
  input  logic [TIER_W-1:0]         tierCfg,
  input  logic [ROW_W-1:0]          rowCfg,
  input  logic                      xferCfg,
  output logic [LATCH_W-1:0]        latchIdx,
  output logic [(1<<TILE_W)-1:0]    tileSel,
  output logic [(1<<TIER_W)-1:0]    tierWrEn,
  output logic [DATA_W/2-1:0]       loByte,
  output logic [DATA_W/2-1:0]       hiByte,
  output logic                      colWrStb,
  output logic [ROW_W-1:0]          rowIdx,
  output logic                      xferStb
);
  localparam int TILES    = 1 << TILE_W;
  localparam int TIERS    = 1 << TIER_W;
  localparam int BYTE_W   = DATA_W / 2;
  localparam int TILE_LSB = LATCH_LSB + LATCH_W;

  logic [LATCH_W-1:0] heldLatch;
  logic [TILE_W-1:0]  heldTile;
  logic [TIER_W-1:0]  heldTier;
  logic [DATA_W-1:0]  heldData;
  logic [ROW_W-1:0]   rowQ;
  logic               xferQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldLatch <= '0;
      heldTile  <= '0;
      heldTier  <= '0;
      heldData  <= '0;
      rowQ      <= '0;
      xferQ     <= 1'b0;
    end else begin
      if (stb.capture) begin
        heldLatch <= busAddr[LATCH_LSB +: LATCH_W];
        heldTile  <= busAddr[TILE_LSB +: TILE_W];
        heldTier  <= tierCfg;
        heldData  <= busData;
      end
      rowQ  <= rowCfg;
      xferQ <= xferCfg;
    end
  end

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    assign tileSel[t] = (heldTile == TILE_W'(t));
  end

  for (genvar v = 0; v < TIERS; v++) begin : g_tier
    assign tierWrEn[v] = stb.wrStb && (heldTier == TIER_W'(v));
  end

  assign latchIdx = heldLatch;
  assign loByte   = heldData[BYTE_W-1:0];
  assign hiByte   = heldData[DATA_W-1:BYTE_W];
  assign colWrStb = stb.wrStb;
  assign rowIdx   = rowQ;
  assign xferStb  = xferQ;
endmodule

// File: rtl/ledbus_wr_if.sv
module ledbus_wr_if
  import ledbus_pkg::*;
#(
  parameter int          ADDR_W      = 26,
  parameter int          DATA_W      = 16,
  parameter logic [25:0] BASE_ADDR   = 26'h2000000,
  parameter int          REGION_LOG2 = 25,
  parameter int          LATCH_LSB   = 1,
  parameter int          LATCH_W     = 4,
  parameter int          TILE_W      = 4,
  parameter int          TIER_W      = 3,
  parameter int          ROW_W       = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busData,
  input  logic                      busWr,
  input  logic                      csN,
  input  logic                      weN,
  input  logic [TIER_W-1:0]         tierCfg,
  input  logic [ROW_W-1:0]          rowCfg,
  input  logic                      xferCfg,
  output logic [LATCH_W-1:0]        latchIdx,
  output logic [(1<<TILE_W)-1:0]    tileSel,
  output logic [(1<<TIER_W)-1:0]    tierWrEn,
  output logic [DATA_W/2-1:0]       loByte,
  output logic [DATA_W/2-1:0]       hiByte,
  output logic                      colWrStb,
  output logic [ROW_W-1:0]          rowIdx,
  output logic                      xferStb
);
  busStb_t stb;

  ledbus_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REGION_LOG2(REGION_LOG2)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .csN(csN), .weN(weN), .stb(stb)
  );

  ledbus_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATCH_LSB(LATCH_LSB),
    .LATCH_W(LATCH_W), .TILE_W(TILE_W), .TIER_W(TIER_W), .ROW_W(ROW_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busData(busData),
    .tierCfg(tierCfg), .rowCfg(rowCfg), .xferCfg(xferCfg),
    .latchIdx(latchIdx), .tileSel(tileSel), .tierWrEn(tierWrEn),
    .loByte(loByte), .hiByte(hiByte), .colWrStb(colWrStb),
    .rowIdx(rowIdx), .xferStb(xferStb)
  );
endmodule

// File: rtl/ledbus_wr_if_chk.sv
module ledbus_wr_if_chk #(
  parameter int DATA_W  = 16,
  parameter int LATCH_W = 4,
  parameter int TILE_W  = 4,
  parameter int TIER_W  = 3,
  parameter int ROW_W   = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   csN,
  input logic                   weN,
  input logic [ROW_W-1:0]       rowCfg,
  input logic                   xferCfg,
  input logic [LATCH_W-1:0]     latchIdx,
  input logic [(1<<TILE_W)-1:0] tileSel,
  input logic [(1<<TIER_W)-1:0] tierWrEn,
  input logic [DATA_W/2-1:0]    loByte,
  input logic [DATA_W/2-1:0]    hiByte,
  input logic                   colWrStb,
  input logic [ROW_W-1:0]       rowIdx,
  input logic                   xferStb
);
  AST_TILE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tileSel) == 1); // R3

  AST_TIER_ONE_WHEN_STB: assert property (@(posedge clk) disable iff (!rstN)
    colWrStb |-> $countones(tierWrEn) == 1); // R4

  AST_TIER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !colWrStb |-> tierWrEn == '0); // R4

  AST_STB_AFTER_WE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(colWrStb) |-> $past(!csN && !weN)); // R5

  AST_STB_DROP_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !colWrStb); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |=> ($stable(latchIdx) && $stable(tileSel)
                               && $stable(loByte) && $stable(hiByte))); // R8

  AST_ROW_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rowIdx == $past(rowCfg) && xferStb == $past(xferCfg))); // R9
endmodule

bind ledbus_wr_if ledbus_wr_if_chk #(
  .DATA_W(DATA_W), .LATCH_W(LATCH_W), .TILE_W(TILE_W),
  .TIER_W(TIER_W), .ROW_W(ROW_W)
) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .rowCfg(rowCfg),
  .xferCfg(xferCfg), .latchIdx(latchIdx), .tileSel(tileSel),
  .tierWrEn(tierWrEn), .loByte(loByte), .hiByte(hiByte),
  .colWrStb(colWrStb), .rowIdx(rowIdx), .xferStb(xferStb)
);

// File: tb/ledbus_wr_if_tb_top.sv
module ledbus_wr_if_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [25:0] busAddr;
  logic [15:0] busData;
  logic        busWr;
  logic        csN;
  logic        weN;
  logic [2:0]  tierCfg;
  logic [3:0]  rowCfg;
  logic        xferCfg;
  logic [3:0]  latchIdx;
  logic [15:0] tileSel;
  logic [7:0]  tierWrEn;
  logic [7:0]  loByte;
  logic [7:0]  hiByte;
  logic        colWrStb;
  logic [3:0]  rowIdx;
  logic        xferStb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ledbus_wr_if dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .busWr(busWr), .csN(csN), .weN(weN), .tierCfg(tierCfg),
    .rowCfg(rowCfg), .xferCfg(xferCfg), .latchIdx(latchIdx),
    .tileSel(tileSel), .tierWrEn(tierWrEn), .loByte(loByte),
    .hiByte(hiByte), .colWrStb(colWrStb), .rowIdx(rowIdx), .xferStb(xferStb)
  );

  typedef struct packed {
    logic [25:0] a;
    logic [15:0] d;
    logic [2:0]  t;
    logic        w;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{26'h2000000, 16'h1234, 3'd0, 1'b1},
    '{26'h200001E, 16'hA5C3, 3'd7, 1'b1},
    '{26'h20001E0, 16'h00FF, 3'd3, 1'b1},
    '{26'h1FFFFFE, 16'hDEAD, 3'd2, 1'b1},
    '{26'h20000A6, 16'hBEEF, 3'd5, 1'b0},
    '{26'h3FFFFFE, 16'h7E81, 3'd6, 1'b1},
    '{26'h0000124, 16'h4242, 3'd1, 1'b1},
    '{26'h20000B4, 16'h55AA, 3'd1, 1'b1}
  };

  // Bench model of the captured state
  logic [3:0]  eLatch;
  logic [3:0]  eTile;
  logic [15:0] eData;
  logic [2:0]  eTier;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkHeld(input string req);
    check(req, 32'(latchIdx), 32'(eLatch));
    check(req, 32'(tileSel), 32'(16'h1 << eTile));
    check(req, 32'(loByte), 32'(eData[7:0]));
    check(req, 32'(hiByte), 32'(eData[15:8]));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One full bus write or read, all edges driven on negedge
  task automatic access(input vec_t v);
    bit hit;
    string tag;
    hit = v.w && (v.a >= 26'h2000000) && (v.a <= 26'h3FFFFFF);
    tag = hit ? "R2" : (v.w ? "R6" : "R7");
    @(negedge clk);
    busAddr = v.a; busData = v.d; tierCfg = v.t; busWr = v.w;
    csN = 1'b0; weN = 1'b1;
    if (hit) begin
      eLatch = v.a[4:1]; eTile = v.a[8:5]; eData = v.d; eTier = v.t;
    end
    @(negedge clk);
    checkHeld(tag);
    check("R3", 32'($countones(tileSel)), 32'd1);
    check("R5", 32'(colWrStb), 32'd0);
    weN = 1'b0;
    @(negedge clk);
    check("R5", 32'(colWrStb), 32'(hit));
    check("R4", 32'(tierWrEn), hit ? 32'(8'h1 << eTier) : 32'd0);
    weN = 1'b1;
    @(negedge clk);
    check("R5", 32'(colWrStb), 32'd0);
    check("R4", 32'(tierWrEn), 32'd0);
    csN = 1'b1;
    @(negedge clk);
    checkHeld(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busData = '0; busWr = 1'b0; csN = 1'b1;
    weN = 1'b1; tierCfg = '0; rowCfg = 4'd5; xferCfg = 1'b1;
    eLatch = '0; eTile = '0; eData = '0; eTier = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 32'(latchIdx), 32'd0);
    check("R1", 32'(tileSel), 32'h1);
    check("R1", 32'(tierWrEn), 32'd0);
    check("R1", 32'(colWrStb), 32'd0);
    check("R1", 32'(rowIdx), 32'd0);
    check("R1", 32'(xferStb), 32'd0);
    check("R1", 32'({hiByte, loByte}), 32'd0);
    rowCfg = '0; xferCfg = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) access(VEC[i]);

    // R8: bus changes while chip select stays low
    @(negedge clk);
    busAddr = 26'h2000042; busData = 16'h1357; tierCfg = 3'd4; busWr = 1'b1;
    csN = 1'b0; weN = 1'b1;
    eLatch = 4'd1; eTile = 4'd2; eData = 16'h1357; eTier = 3'd4;
    @(negedge clk);
    busAddr = 26'h20001FE; busData = 16'hFFFF; tierCfg = 3'd0;
    @(negedge clk);
    checkHeld("R8");
    weN = 1'b0;
    @(negedge clk);
    check("R8", 32'(tierWrEn), 32'(8'h1 << 4));
    checkHeld("R8");
    // R5: chip select released while write enable still low
    csN = 1'b1;
    @(negedge clk);
    check("R5", 32'(colWrStb), 32'd0);
    check("R4", 32'(tierWrEn), 32'd0);
    weN = 1'b1;

    // R9: row index and transfer strobe follow with one cycle delay
    @(negedge clk);
    rowCfg = 4'd9; xferCfg = 1'b1;
    @(negedge clk);
    check("R9", 32'(rowIdx), 32'd9);
    check("R9", 32'(xferStb), 32'd1);
    rowCfg = 4'd15; xferCfg = 1'b0;
    @(negedge clk);
    check("R9", 32'(rowIdx), 32'd15);
    check("R9", 32'(xferStb), 32'd0);

    done = 1'b1;
    finishRun();
  end
endmodule